// File: doc/BRIEF.md
# Synchronous Rectifier Fault and Protection Supervisor

This block sits between the comparator outputs of a secondary-side synchronous rectifier controller and its gate drivers. It takes one digitized flag for each fault condition and produces a single drive-enable. It also keeps a register that names the fault that tripped first, and it raises a shrink request whenever the feedback level jumps between two switching cycles. All comparators and analog sensing are outside the block. Every input flag arrives already synchronous to `clk`.

Each fault source has its own timing and its own recovery rule. The programming-pin faults (pin pulled too low or floating too high) and the output-short fault are debounced, and they stay latched until an under-voltage lockout episode clears them. Supply over-voltage is debounced and releases itself when a separate release flag reports that the supply has dropped by the hysteresis margin. Over-temperature acts at once and clears only on its own cool-down flag. On every cycle strobe, the feedback sample is compared with the sample from the previous cycle. A rise of more than 20 % starts a shrink window of fixed length.

Top module: `sr_fault_supervisor`

## Requirements
- R1: After reset `drv_en_o`, `fault_o` and `shrink_o` are all 0. While `uv_i` is 1, `drv_en_o` is 0. One cycle after `uv_i` falls with no fault active, `drv_en_o` is 1.
- R2: `pin_low_i` or `pin_high_i` held high for PIN_DB consecutive clock edges trips a fault that sets `fault_o` bit 0 (low) or bit 1 (high) and clears `drv_en_o`. The fault stays latched after the flag drops, until the next lockout.
- R3: A fault flag that drops before its debounce count completes trips nothing and restarts its count from zero.
- R4: `fb_short_i` held high for SCP_DB consecutive edges trips a latched fault that sets `fault_o` bit 2 and clears `drv_en_o`. SCP_DB-1 edges are not enough.
- R5: `ov_i` held high for OVP_DB consecutive edges disables drive and sets `fault_o` bit 3. Drive stays off after `ov_i` drops, and it returns one cycle after `ov_rel_i` is seen high.
- R6: `ot_hot_i` disables drive on the next edge and sets `fault_o` bit 4. Only `ot_cool_i` re-enables drive; a lockout does not clear this fault.
- R7: `fault_o` is one-hot or zero. It reports the first fault to trip and holds it until lockout, even after that fault recovers or others trip. When several trip on the same edge, the lowest bit index wins.
- R8: A lockout (`uv_i` high) clears the latched faults, the over-voltage fault, `fault_o`, the shrink window and the stored feedback sample.
- R9: On a strobe where 5·`fb_i` > 6·(previous strobed sample), `shrink_o` is high for exactly SHR_LEN cycles, starting in the cycle after the strobe. A previous sample of 0 counts as a rise for any nonzero sample.
- R10: The first strobe after reset or lockout never starts a shrink. A sample of exactly 120 % of the previous one does not start a shrink.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| pin_low_i | input | 1 | Programming pin below its short limit |
| pin_high_i | input | 1 | Programming pin above its open limit |
| fb_short_i | input | 1 | Supply-minus-feedback below the short-circuit threshold |
| ov_i | input | 1 | Supply above the over-voltage limit |
| ov_rel_i | input | 1 | Supply below the over-voltage limit less hysteresis |
| ot_hot_i | input | 1 | Die above the shutdown temperature |
| ot_cool_i | input | 1 | Die below the restart temperature |
| uv_i | input | 1 | Supply under the lockout threshold (hysteresis applied outside) |
| fb_i | input | FB_W | Feedback sample for the current switching cycle |
| stb_i | input | 1 | Cycle strobe; `fb_i` is taken when high |
| drv_en_o | output | 1 | Gate drive enable |
| fault_o | output | 5 | First-tripped fault, one bit per source |
| shrink_o | output | 1 | Gate shrink request |

## Verification
Each fault source is held for exactly its debounce length and for one edge less. It is also held in two short bursts whose total exceeds the length, which exposes a counter that fails to restart. The recovery rules are told apart by dropping the flag, then applying a lockout or the release flag, and watching the enable at each step. A second fault that trips later, and two that trip on the same edge, show first-fault capture and its priority. The feedback stimulus runs through an exact-120 % step, steps just above it, a fall, a zero baseline and a full-scale jump. Each is followed by a check of the window length, and a stale-history probe after lockout checks that the stored sample was cleared.

// File: rtl/sup_pkg.sv
package sup_pkg;
  localparam int NFLT   = 5;
  localparam int F_PLO  = 0;
  localparam int F_PHI  = 1;
  localparam int F_SCP  = 2;
  localparam int F_OVP  = 3;
  localparam int F_OTP  = 4;
  localparam int NDB    = 4;
  typedef logic [NFLT-1:0] flt_vec_t;
endpackage

// File: rtl/sup_debounce.sv
module sup_debounce #(
  parameter int DB = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic flag_i,
  output logic trip_o
);
  localparam int CW = (DB < 2) ? 1 : $clog2(DB);
  localparam logic [CW-1:0] LAST = CW'(DB - 1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          cnt_en;

  always_comb begin
    cnt_en  = 1'b1;
    cnt_nxt = cnt_q;
    if (clr_i || !flag_i) begin
      cnt_nxt = '0;
    end else if (cnt_q == LAST) begin
      cnt_en  = 1'b0;
    end else begin
      cnt_nxt = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign trip_o = flag_i && !clr_i && (cnt_q == LAST);

  AST_DB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);  // R3
  AST_DB_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_i |=> cnt_q == '0);  // R3
endmodule

// File: rtl/sup_shrink.sv
module sup_shrink #(
  parameter int FB_W    = 10,
  parameter int SHR_LEN = 4500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            stb_i,
  input  logic [FB_W-1:0] fb_i,
  output logic            shrink_o
);
  localparam int PW = FB_W + 3;
  localparam int TW = $clog2(SHR_LEN + 1);

  logic [FB_W-1:0] prev_q;
  logic            vld_q;
  logic [TW-1:0]   tmr_q, tmr_nxt;
  logic [PW-1:0]   now_x5, prev_x6;
  logic            rise;

  always_comb begin
    now_x5  = PW'(fb_i) * PW'(5);
    prev_x6 = PW'(prev_q) * PW'(6);
    rise    = stb_i && vld_q && (now_x5 > prev_x6);
    if (clr_i) begin
      tmr_nxt = '0;
    end else if (rise) begin
      tmr_nxt = TW'(SHR_LEN);
    end else if (tmr_q != '0) begin
      tmr_nxt = tmr_q - 1'b1;
    end else begin
      tmr_nxt = tmr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      vld_q  <= 1'b0;
    end else if (clr_i) begin
      prev_q <= '0;
      vld_q  <= 1'b0;
    end else if (stb_i) begin
      prev_q <= fb_i;
      vld_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else begin
      tmr_q <= tmr_nxt;
    end
  end

  assign shrink_o = (tmr_q != '0);

  AST_SHR_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shrink_o) |-> $past(stb_i));  // R9
  AST_SHR_FIRST_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && !vld_q) |=> !shrink_o);  // R10
  AST_SHR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !shrink_o);  // R8
endmodule

// File: rtl/sr_fault_supervisor.sv
module sr_fault_supervisor
  import sup_pkg::*;
#(
  parameter int FB_W    = 10,
  parameter int PIN_DB  = 100,
  parameter int SCP_DB  = 800,
  parameter int OVP_DB  = 3000,
  parameter int SHR_LEN = 4500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin_low_i,
  input  logic            pin_high_i,
  input  logic            fb_short_i,
  input  logic            ov_i,
  input  logic            ov_rel_i,
  input  logic            ot_hot_i,
  input  logic            ot_cool_i,
  input  logic            uv_i,
  input  logic [FB_W-1:0] fb_i,
  input  logic            stb_i,
  output logic            drv_en_o,
  output logic [4:0]      fault_o,
  output logic            shrink_o
);
  function automatic int db_of(input int idx);
    case (idx)
      F_PLO, F_PHI: return PIN_DB;
      F_SCP:        return SCP_DB;
      default:      return OVP_DB;
    endcase
  endfunction

  logic [NDB-1:0] db_flag, db_trip;
  flt_vec_t       set_v, flt_q, flt_nxt, code_q, code_nxt;
  logic           run_q;

  assign db_flag = {ov_i, fb_short_i, pin_high_i, pin_low_i};

  for (genvar g = 0; g < NDB; g++) begin : g_db
    sup_debounce #(.DB(db_of(g))) i_db (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (uv_i),
      .flag_i (db_flag[g]),
      .trip_o (db_trip[g])
    );
  end

  sup_shrink #(.FB_W(FB_W), .SHR_LEN(SHR_LEN)) i_shrink (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (uv_i),
    .stb_i    (stb_i),
    .fb_i     (fb_i),
    .shrink_o (shrink_o)
  );

  always_comb begin
    set_v        = {ot_hot_i, db_trip};
    flt_nxt      = flt_q;
    flt_nxt[F_PLO] = flt_q[F_PLO] | set_v[F_PLO];
    flt_nxt[F_PHI] = flt_q[F_PHI] | set_v[F_PHI];
    flt_nxt[F_SCP] = flt_q[F_SCP] | set_v[F_SCP];
    if (set_v[F_OVP])      flt_nxt[F_OVP] = 1'b1;
    else if (ov_rel_i)     flt_nxt[F_OVP] = 1'b0;
    if (set_v[F_OTP])      flt_nxt[F_OTP] = 1'b1;
    else if (ot_cool_i)    flt_nxt[F_OTP] = 1'b0;
    if (uv_i) begin
      flt_nxt[F_PLO] = 1'b0;
      flt_nxt[F_PHI] = 1'b0;
      flt_nxt[F_SCP] = 1'b0;
      flt_nxt[F_OVP] = 1'b0;
    end
  end

  always_comb begin
    code_nxt = code_q;
    if (uv_i) begin
      code_nxt = '0;
    end else if (code_q == '0) begin
      code_nxt = set_v & flt_vec_t'(~set_v + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q  <= '0;
      code_q <= '0;
      run_q  <= 1'b0;
    end else begin
      flt_q  <= flt_nxt;
      code_q <= code_nxt;
      run_q  <= !uv_i;
    end
  end

  assign drv_en_o = run_q && (flt_q == '0);
  assign fault_o  = code_q;

  AST_PLO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_q[F_PLO]) |-> $past(pin_low_i));  // R2
  AST_PLO_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q[F_PLO] && !uv_i) |=> flt_q[F_PLO]);  // R2
  AST_SCP_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q[F_SCP] && !uv_i) |=> flt_q[F_SCP]);  // R4
  AST_OVP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q[F_OVP] && !ov_rel_i && !uv_i) |=> flt_q[F_OVP]);  // R5
  AST_OTP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q[F_OTP] && !ot_cool_i) |=> flt_q[F_OTP]);  // R6
  AST_CODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault_o));  // R7
  AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o != '0 && !uv_i) |=> $stable(fault_o));  // R7
  AST_UV_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> (!drv_en_o && fault_o == '0));  // R8
endmodule

// File: tb/test_sr_fault_supervisor.sv
module test_sr_fault_supervisor;
  localparam int FB_W    = 10;
  localparam int PIN_DB  = 8;
  localparam int SCP_DB  = 12;
  localparam int OVP_DB  = 20;
  localparam int SHR_LEN = 30;
  localparam int NVEC    = 9;
  // {feedback sample, expected shrink after the strobe}
  localparam logic [FB_W:0] VEC [NVEC] = '{
    {10'd100, 1'b0}, {10'd120, 1'b0}, {10'd145, 1'b1}, {10'd145, 1'b0},
    {10'd100, 1'b0}, {10'd121, 1'b1}, {10'd0,   1'b0}, {10'd1,   1'b1},
    {10'd1023, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, pin_low, pin_high, fb_short, ov, ov_rel, ot_hot, ot_cool, uv, stb;
  logic [FB_W-1:0] fb;
  logic drv_en, shrink;
  logic [4:0] fault;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sr_fault_supervisor #(.FB_W(FB_W), .PIN_DB(PIN_DB), .SCP_DB(SCP_DB),
                        .OVP_DB(OVP_DB), .SHR_LEN(SHR_LEN)) i_sr_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .pin_low_i(pin_low), .pin_high_i(pin_high),
    .fb_short_i(fb_short), .ov_i(ov), .ov_rel_i(ov_rel), .ot_hot_i(ot_hot),
    .ot_cool_i(ot_cool), .uv_i(uv), .fb_i(fb), .stb_i(stb),
    .drv_en_o(drv_en), .fault_o(fault), .shrink_o(shrink)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lockout();
    uv = 1'b1; cyc(2); uv = 1'b0; cyc(1);
  endtask

  task automatic strobe(input logic [FB_W-1:0] v);
    fb = v; stb = 1'b1; cyc(1); stb = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; uv = 1'b1; pin_low = 0; pin_high = 0; fb_short = 0;
    ov = 0; ov_rel = 0; ot_hot = 0; ot_cool = 0; stb = 0; fb = '0;
    cyc(3);
    check("R1 reset enable", drv_en, 0);
    check("R1 reset code", fault, 0);
    check("R1 reset shrink", shrink, 0);
    rst_n = 1'b1; cyc(3);
    check("R1 lockout holds drive off", drv_en, 0);
    uv = 1'b0; cyc(1);
    check("R1 enable after lockout", drv_en, 1);

    // R9 R10: table of feedback steps
    for (int i = 0; i < NVEC; i++) begin
      strobe(VEC[i][FB_W:1]);
      check("R9 shrink start", shrink, int'(VEC[i][0]));
      cyc(SHR_LEN - 1);
      check("R9 shrink last cycle", shrink, int'(VEC[i][0]));
      cyc(1);
      check("R9 shrink ended", shrink, 0);
      check("R9 drive unaffected", drv_en, 1);
    end

    // R8 R10: history cleared by lockout
    strobe(10'd10); cyc(2);
    lockout();
    strobe(10'd100);
    check("R10 first sample after lockout", shrink, 0);
    strobe(10'd700);
    check("R9 shrink after rise", shrink, 1);
    uv = 1'b1; cyc(1);
    check("R8 lockout clears shrink", shrink, 0);
    uv = 1'b0; cyc(1);

    // R3: interrupted debounce
    pin_low = 1; cyc(PIN_DB - 1); pin_low = 0; cyc(1);
    pin_low = 1; cyc(PIN_DB - 1); pin_low = 0; cyc(2);
    check("R3 no trip on short bursts", drv_en, 1);
    check("R3 no code on short bursts", fault, 0);

    // R2 R7: pin low trips, latches; later pin high does not change code
    pin_low = 1; cyc(PIN_DB);
    check("R2 pin low trips", drv_en, 0);
    check("R2 pin low code", fault, 1);
    pin_low = 0; cyc(5);
    check("R2 latched after drop", drv_en, 0);
    pin_high = 1; cyc(PIN_DB); pin_high = 0; cyc(1);
    check("R7 first fault kept", fault, 1);
    uv = 1'b1; cyc(2);
    check("R8 lockout clears code", fault, 0);
    check("R8 lockout drive off", drv_en, 0);
    uv = 1'b0; cyc(1);
    check("R8 drive back after lockout", drv_en, 1);

    pin_high = 1; cyc(PIN_DB); pin_high = 0;
    check("R2 pin high code", fault, 2);
    check("R2 pin high drive off", drv_en, 0);
    lockout();

    // R4
    fb_short = 1; cyc(SCP_DB - 1);
    check("R4 no trip one edge early", drv_en, 1);
    cyc(1);
    check("R4 short trips", drv_en, 0);
    check("R4 short code", fault, 4);
    fb_short = 0; cyc(3);
    check("R4 short latched", drv_en, 0);
    lockout();

    // R5
    ov = 1; cyc(OVP_DB - 1);
    check("R5 no trip one edge early", drv_en, 1);
    cyc(1);
    check("R5 ov trips", drv_en, 0);
    check("R5 ov code", fault, 8);
    ov = 0; cyc(5);
    check("R5 waits for release", drv_en, 0);
    ov_rel = 1; cyc(1); ov_rel = 0;
    check("R5 auto recovery", drv_en, 1);
    check("R7 code kept after recovery", fault, 8);
    lockout();

    // R6
    ot_hot = 1; cyc(1); ot_hot = 0;
    check("R6 ot immediate", drv_en, 0);
    check("R6 ot code", fault, 16);
    cyc(3);
    check("R6 ot held", drv_en, 0);
    lockout();
    check("R6 ot survives lockout", drv_en, 0);
    check("R8 code cleared", fault, 0);
    ot_cool = 1; cyc(1); ot_cool = 0;
    check("R6 ot released by cool flag", drv_en, 1);

    // R7: simultaneous trips
    pin_low = 1; pin_high = 1; cyc(PIN_DB); pin_low = 0; pin_high = 0;
    check("R7 lowest index wins", fault, 1);
    lockout();
    check("R1 clean after all tests", drv_en, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule